// File: doc/BRIEF.md
# Locked Configuration Index/Data Port

This block is the configuration front end of a legacy I/O controller that sits on a simple byte-wide port bus. Software reaches it through two adjacent port addresses: the lower one takes a register index, the upper one reads or writes the register that index points to. The pair lives at 0x2E/0x2F by default. A strap input moves it to 0x4E/0x4F. Accesses to any other address are not claimed and have no effect.

Configuration space is closed after reset. Writing the enter key 0x87 twice in a row to the index port opens it. Writing the exit key 0xAA to the index port closes it again. The gate is a three-state machine:

- `ST_LOCKED` moves to `ST_KEY1` on an index write of 0x87.
- `ST_KEY1` moves to `ST_OPEN` on a second 0x87. Any other index write sends it back to `ST_LOCKED`.
- `ST_OPEN` returns to `ST_LOCKED` on 0xAA. Every other index write in `ST_OPEN` is latched as the current index.

While the gate is open, the block serves these registers:

- The logical-device select register at index 0x07.
- A read-only chip identification pair at 0x20/0x21.
- A global option register at 0x24, whose bit 1 enables the floppy controller that shares pins with GPIO port 6.
- A pin-multiplex register at 0x2C.
- Indices 0x30 and 0xE0..0xE3, which are banked: each logical device has its own copy, chosen by the select register.

Bit 0 of a device's 0x30 register is its activate output. Its 0xE0.. registers are exported in a flat vector to drive that device.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the gate is closed, the device select register and the 0x24 and 0x2C registers read 0x00, and every activate output is 0.
- R2: A single 0x87 index write does not open the gate. An index write of any other value after one 0x87 restarts the key count, so the sequence 0x87, 0x55, 0x87 leaves the gate closed.
- R3: Two consecutive 0x87 index writes, with no other index write between them, raise `cfg_unlocked` after the edge of the second write.
- R4: An index write of 0xAA while open lowers `cfg_unlocked` after that edge. That write is not latched as an index.
- R5: While closed, data-port writes change no register, and reads of either port return 0xFF.
- R6: With `alt_base` = 0 the index port is 0x2E and the data port is 0x2F. With `alt_base` = 1 they are 0x4E and 0x4F. Writes elsewhere are ignored, and reads elsewhere return 0x00 with `bus_hit` low. An open index-port read returns the latched index.
- R7: Index 0x20 reads 0xA2 and index 0x21 reads {0x3, REV} (0x30 by default), giving a 16-bit ID whose upper 12 bits are 0xA23. Writes to them are ignored.
- R8: Index 0x2C is a read/write byte, and its bits [1:0] drive `pin_func`: 0 = infrared off, 1 = infrared, 2 = GPIO port 1, 3 = second UART.
- R9: Index 0x24 is a read/write byte, and its bit 1 drives `fdc_en`.
- R10: Index 0x07 selects a logical device. Indices 0x30 and 0xE0..0xE3 then address that device's own copy. `dev_active[n]` is bit 0 of device n's 0x30. Register r of device n appears at `dev_bank[(n*4+r)*8 +: 8]`.
- R11: Undefined indices read 0x00 and ignore writes. When the selected device number is 16 or above, the banked indices read 0x00 and ignore writes.
- R12: Asserting the asynchronous reset while open closes the gate and clears the registers at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_base | input | 1 | Strap: 0 selects 0x2E/0x2F, 1 selects 0x4E/0x4F |
| bus_addr | input | 16 | Port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during the read cycle |
| bus_hit | output | 1 | The access addresses this block's index or data port |
| cfg_unlocked | output | 1 | Configuration gate is open |
| pin_func | output | 2 | Pin-multiplex function select |
| fdc_en | output | 1 | Floppy controller enable |
| dev_active | output | 16 | Per-device activate bits |
| dev_bank | output | 512 | Per-device banked registers, 4 bytes per device |

## Verification
The hardest case to reach is the key counter being restarted by an intervening index write, because from the ports it looks exactly like a plain single key. The stimulus writes 0x87, then 0x55, then 0x87. It confirms the gate is still closed, and a fourth write of 0x87 must then open it. Bank isolation is reached by selecting two devices in turn, writing different values into each, and reading back across the switch. An out-of-range device number is then written to show that the activate vector is left untouched. The reset case pulls reset between clock edges and checks the outputs before the next edge.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_KEY1   = 2'd1,
        ST_OPEN   = 2'd2
    } lock_st_e;

    localparam logic [7:0]  KEY_ENTER     = 8'h87;
    localparam logic [7:0]  KEY_EXIT      = 8'hAA;
    localparam logic [7:0]  IDX_LDN       = 8'h07;
    localparam logic [7:0]  IDX_ID_HI     = 8'h20;
    localparam logic [7:0]  IDX_ID_LO     = 8'h21;
    localparam logic [7:0]  IDX_GOPT      = 8'h24;
    localparam logic [7:0]  IDX_PINMUX    = 8'h2C;
    localparam logic [7:0]  IDX_BANK_EN   = 8'h30;
    localparam logic [7:0]  IDX_BANK_BASE = 8'hE0;
    localparam logic [11:0] CHIP_ID_HI12  = 12'hA23;
endpackage

// File: rtl/sio_cfg_lock.sv
module sio_cfg_lock
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);
    lock_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                ST_LOCKED: if (wdata == KEY_ENTER) state_d = ST_KEY1;
                ST_KEY1:   state_d = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
                ST_OPEN:   if (wdata == KEY_EXIT) state_d = ST_LOCKED;
                default:   state_d = ST_LOCKED;
            endcase
        end
    end

    always_comb begin
        unlocked = (state_q == ST_OPEN);
    end

    // R3
    key_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_ENTER));

    // R2
    single_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |=> (state_q != ST_OPEN));

    // R4
    lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && idx_wr && wdata == KEY_EXIT) |=> !unlocked);
endmodule

// File: rtl/sio_cfg_glob.sv
module sio_cfg_glob
    import sio_cfg_pkg::*;
#(
    parameter logic [3:0] REV = 4'h0
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] ldn,
    output logic [1:0] pin_func,
    output logic       fdc_en,
    output logic [7:0] rdata
);
    logic [7:0] ldn_q, gopt_q, pinmux_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ldn_q    <= 8'h00;
            gopt_q   <= 8'h00;
            pinmux_q <= 8'h00;
        end else if (wr_en) begin
            if (idx == IDX_LDN)    ldn_q    <= wdata;
            if (idx == IDX_GOPT)   gopt_q   <= wdata;
            if (idx == IDX_PINMUX) pinmux_q <= wdata;
        end
    end

    always_comb begin
        unique case (idx)
            IDX_LDN:    rdata = ldn_q;
            IDX_ID_HI:  rdata = CHIP_ID_HI12[11:4];
            IDX_ID_LO:  rdata = {CHIP_ID_HI12[3:0], REV};
            IDX_GOPT:   rdata = gopt_q;
            IDX_PINMUX: rdata = pinmux_q;
            default:    rdata = 8'h00;
        endcase
    end

    assign ldn      = ldn_q;
    assign pin_func = pinmux_q[1:0];
    assign fdc_en   = gopt_q[1];

    // R9
    fdc_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_GOPT) |=> (fdc_en == $past(wdata[1])));
endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
    import sio_cfg_pkg::*;
#(
    parameter int NUM_LDN = 16,
    parameter int BANK_N  = 4
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                idx,
    input  logic [7:0]                ldn,
    input  logic [7:0]                wdata,
    output logic [NUM_LDN-1:0]        dev_active,
    output logic [NUM_LDN*BANK_N*8-1:0] dev_bank,
    output logic [7:0]                rdata
);
    localparam int LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

    logic [7:0]           hi_off;
    logic                 hi_sel, en_sel, ldn_ok;
    logic [LDN_W-1:0]     sel;
    logic [NUM_LDN*8-1:0] en_all;

    assign hi_off = idx - IDX_BANK_BASE;
    assign hi_sel = (idx >= IDX_BANK_BASE) && ({1'b0, hi_off} < 9'(BANK_N));
    assign en_sel = (idx == IDX_BANK_EN);
    assign ldn_ok = ({1'b0, ldn} < 9'(NUM_LDN));
    assign sel    = ldn[LDN_W-1:0];

    for (genvar d = 0; d < NUM_LDN; d++) begin : g_dev
        logic hit_dev;
        logic [7:0] en_q;
        assign hit_dev = wr_en && ldn_ok && (ldn == 8'(d));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 en_q <= 8'h00;
            else if (hit_dev && en_sel) en_q <= wdata;
        end
        assign en_all[d*8 +: 8] = en_q;
        assign dev_active[d]    = en_q[0];

        for (genvar r = 0; r < BANK_N; r++) begin : g_reg
            logic [7:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    val_q <= 8'h00;
                else if (hit_dev && hi_sel && (hi_off == 8'(r)))
                    val_q <= wdata;
            end
            assign dev_bank[(d*BANK_N + r)*8 +: 8] = val_q;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (ldn_ok) begin
            if (en_sel)      rdata = en_all[int'(sel)*8 +: 8];
            else if (hi_sel) rdata = dev_bank[(int'(sel)*BANK_N + int'(hi_off))*8 +: 8];
        end
    end

    // R11
    bad_ldn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldn_ok) |=> $stable(dev_active));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          NUM_LDN  = 16,
    parameter int          BANK_N   = 4,
    parameter logic [15:0] BASE_PRI = 16'h002E,
    parameter logic [15:0] BASE_ALT = 16'h004E,
    parameter logic [3:0]  REV      = 4'h0
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alt_base,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    output logic                        bus_hit,
    output logic                        cfg_unlocked,
    output logic [1:0]                  pin_func,
    output logic                        fdc_en,
    output logic [NUM_LDN-1:0]          dev_active,
    output logic [NUM_LDN*BANK_N*8-1:0] dev_bank
);
    logic [ADDR_W-1:0] base;
    logic              hit_idx, hit_dat, idx_wr, dat_wr;
    logic [7:0]        idx_q, ldn, glob_rdata, bank_rdata;

    assign base    = alt_base ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_PRI);
    assign hit_idx = (bus_addr == base);
    assign hit_dat = (bus_addr == base + ADDR_W'(1));
    assign bus_hit = (bus_wr || bus_rd) && (hit_idx || hit_dat);
    assign idx_wr  = bus_wr && hit_idx;
    assign dat_wr  = bus_wr && hit_dat && cfg_unlocked;

    sio_cfg_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .unlocked (cfg_unlocked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= 8'h00;
        else if (idx_wr && cfg_unlocked && bus_wdata != KEY_EXIT)
            idx_q <= bus_wdata;
    end

    sio_cfg_glob #(.REV(REV)) u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dat_wr && (idx_q < IDX_BANK_EN)),
        .idx      (idx_q),
        .wdata    (bus_wdata),
        .ldn      (ldn),
        .pin_func (pin_func),
        .fdc_en   (fdc_en),
        .rdata    (glob_rdata)
    );

    sio_cfg_bank #(.NUM_LDN(NUM_LDN), .BANK_N(BANK_N)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (dat_wr && (idx_q >= IDX_BANK_EN)),
        .idx        (idx_q),
        .ldn        (ldn),
        .wdata      (bus_wdata),
        .dev_active (dev_active),
        .dev_bank   (dev_bank),
        .rdata      (bank_rdata)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd && (hit_idx || hit_dat)) begin
            if (!cfg_unlocked)          bus_rdata = 8'hFF;
            else if (hit_idx)           bus_rdata = idx_q;
            else if (idx_q < IDX_BANK_EN) bus_rdata = glob_rdata;
            else                        bus_rdata = bank_rdata;
        end
    end

    // R5
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_hit && !cfg_unlocked) |-> (bus_rdata == 8'hFF));

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |=> ($stable(pin_func) && $stable(fdc_en) && $stable(dev_active)));

    // R6
    miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_hit) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         alt_base = 1'b0;
    logic [15:0]  bus_addr = 16'h0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_wdata = 8'h0;
    logic [7:0]   bus_rdata;
    logic         bus_hit, cfg_unlocked, fdc_en;
    logic [1:0]   pin_func;
    logic [15:0]  dev_active;
    logic [511:0] dev_bank;

    int total = 0;
    int bad = 0;
    logic [15:0] base_a = 16'h002E;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    sio_cfg_port u_sio_cfg_port (
        .clk(clk), .rst_n(rst_n), .alt_base(alt_base),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
        .cfg_unlocked(cfg_unlocked), .pin_func(pin_func), .fdc_en(fdc_en),
        .dev_active(dev_active), .dev_bank(dev_bank)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares every read against the scoreboard queue
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard empty actual=%0h expected=none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 32'(bus_rdata), 32'(e));
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic cfg_wr(input logic [7:0] i, input logic [7:0] d);
        wr(base_a, i);
        wr(base_a + 16'd1, d);
    endtask

    task automatic cfg_rd(input logic [7:0] i, input logic [7:0] e, input string tag);
        wr(base_a, i);
        rd(base_a + 16'd1, e, tag);
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 unlocked", 32'(cfg_unlocked), 0);
        chk("R1 pin_func", 32'(pin_func), 0);
        chk("R1 fdc_en", 32'(fdc_en), 0);
        chk("R1 dev_active", 32'(dev_active), 0);
        rd(16'h002F, 8'hFF, "R5 locked data read");
        rd(16'h002E, 8'hFF, "R5 locked index read");

        // locked data write must be ignored
        wr(16'h002E, 8'h2C);
        wr(16'h002F, 8'h03);
        chk("R5 locked write pin_func", 32'(pin_func), 0);

        // key counter restart
        wr(16'h002E, 8'h87);
        chk("R2 single key", 32'(cfg_unlocked), 0);
        wr(16'h002E, 8'h55);
        wr(16'h002E, 8'h87);
        chk("R2 restarted key", 32'(cfg_unlocked), 0);
        wr(16'h002E, 8'h87);
        chk("R3 unlocked", 32'(cfg_unlocked), 1);

        // chip ID
        cfg_rd(8'h20, 8'hA2, "R7 id hi");
        cfg_rd(8'h21, 8'h30, "R7 id lo");
        cfg_wr(8'h20, 8'h11);
        cfg_rd(8'h20, 8'hA2, "R7 id write ignored");

        // pin multiplex
        cfg_wr(8'h2C, 8'h02);
        chk("R8 pin_func gpio1", 32'(pin_func), 2);
        cfg_wr(8'h2C, 8'h03);
        chk("R8 pin_func uart", 32'(pin_func), 3);
        cfg_wr(8'h2C, 8'hF1);
        chk("R8 pin_func ir", 32'(pin_func), 1);
        cfg_rd(8'h2C, 8'hF1, "R8 readback");

        // global option
        cfg_wr(8'h24, 8'h02);
        chk("R9 fdc on", 32'(fdc_en), 1);
        cfg_wr(8'h24, 8'hFD);
        chk("R9 fdc off", 32'(fdc_en), 0);
        cfg_rd(8'h24, 8'hFD, "R9 readback");

        // banked registers
        cfg_wr(8'h07, 8'h03);
        cfg_wr(8'h30, 8'h01);
        cfg_wr(8'hE0, 8'h5A);
        cfg_wr(8'h07, 8'h08);
        cfg_wr(8'h30, 8'h01);
        cfg_wr(8'hE1, 8'hC3);
        cfg_rd(8'hE0, 8'h00, "R10 dev8 reg0");
        cfg_rd(8'hE1, 8'hC3, "R10 dev8 reg1");
        cfg_wr(8'h07, 8'h03);
        cfg_rd(8'hE0, 8'h5A, "R10 dev3 reg0");
        cfg_rd(8'hE1, 8'h00, "R10 dev3 reg1");
        cfg_rd(8'h30, 8'h01, "R10 dev3 enable");
        cfg_rd(8'h07, 8'h03, "R10 select readback");
        chk("R10 dev_active", 32'(dev_active), 32'h0108);
        chk("R10 dev_bank dev3", 32'(dev_bank[(3*4+0)*8 +: 8]), 32'h5A);
        chk("R10 dev_bank dev8", 32'(dev_bank[(8*4+1)*8 +: 8]), 32'hC3);
        rd(16'h002E, 8'h07, "R6 index readback");

        // undefined registers
        cfg_rd(8'h10, 8'h00, "R11 undefined read");
        cfg_wr(8'h10, 8'hFF);
        cfg_rd(8'h10, 8'h00, "R11 undefined after write");
        cfg_rd(8'h31, 8'h00, "R11 bank hole");
        cfg_rd(8'hE4, 8'h00, "R11 beyond bank");
        cfg_wr(8'h07, 8'h20);
        cfg_wr(8'h30, 8'h01);
        chk("R11 bad ldn active", 32'(dev_active), 32'h0108);
        cfg_rd(8'h30, 8'h00, "R11 bad ldn read");

        // other address pair ignored
        wr(16'h004E, 8'h2C);
        wr(16'h004F, 8'h00);
        chk("R6 stray write", 32'(pin_func), 1);
        rd(16'h004F, 8'h00, "R6 stray read");

        // exit key
        cfg_rd(8'h2C, 8'hF1, "R8 before lock");
        wr(16'h002E, 8'hAA);
        chk("R4 locked", 32'(cfg_unlocked), 0);
        wr(16'h002F, 8'h02);
        chk("R5 write after lock", 32'(pin_func), 1);
        rd(16'h002F, 8'hFF, "R5 read after lock");

        // async reset while open
        wr(16'h002E, 8'h87);
        wr(16'h002E, 8'h87);
        cfg_wr(8'h24, 8'h02);
        chk("R12 pre fdc", 32'(fdc_en), 1);
        @(posedge clk); #2;
        rst_n = 1'b0;
        #1;
        chk("R12 unlocked", 32'(cfg_unlocked), 0);
        chk("R12 fdc", 32'(fdc_en), 0);
        chk("R12 pin_func", 32'(pin_func), 0);
        alt_base = 1'b1;
        @(posedge clk); #1;
        rst_n = 1'b1;

        // alternate base
        base_a = 16'h004E;
        wr(16'h002E, 8'h87);
        wr(16'h002E, 8'h87);
        chk("R6 primary ignored", 32'(cfg_unlocked), 0);
        wr(16'h004E, 8'h87);
        wr(16'h004E, 8'h87);
        chk("R6 alt unlocked", 32'(cfg_unlocked), 1);
        cfg_rd(8'h20, 8'hA2, "R6 alt id");
        cfg_rd(8'h07, 8'h00, "R1 select after reset");
        rd(16'h002F, 8'h00, "R6 primary read miss");

        repeat (3) @(posedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule